// File: doc/BRIEF.md
# Miss Holding Entry Merge Controller

This block sits beside a table of outstanding miss entries in a cache. When a new miss arrives for a line that already has an entry in flight, the lookup logic presents the request together with the index of the matching entry. The block then decides whether the request can join that entry or must wait. The answer is one of four codes. The request may be merged. It may be held because the entry is already being returned. It may be held to keep write-after-read order. Or it may be held because the entry has no free merge slot.

Each entry keeps a few pieces of state. These are a draining flag, a sticky ordering-hold flag, a merge count and a write-seen flag. Each entry also records whether its first request was a read, whether everything it holds so far is a prefetch, the class of its first prefetch, and the cycle at which a demand request first joined a prefetch-only entry. Two running counters record late-but-useful prefetches, one for software prefetches and one for hardware prefetches.

An allocation port starts an entry from the first request's type and prefetch code. A drain port marks an entry as being returned.

Top module: `mshr_coal_ctrl`

## Requirements
- R1: A request to an entry whose draining flag is set returns code 1 (drain hold). The entry state does not change, even when the entry is also under an ordering hold or is full.
- R2: While an entry's sticky ordering flag is set, every request returns code 2 (ordering hold), reads included. Only a new allocation clears the flag.
- R3: A request that is not a read (type 1 write, 2 read-modify-write, 3 upgrade) to an entry whose first request was a read (type 0) sets the sticky ordering flag and returns code 2.
- R4: When the merge count equals MAX_COAL-1, the request returns code 3 (full) and the count stays unchanged.
- R5: Otherwise the request returns code 0 (merged). rsp_slot reports the count before the merge, and the count increases by one.
- R6: On each merge, the write-seen flag is set if the request type is 1 or 2 and cleared otherwise. A held request leaves the flag unchanged.
- R7: A prefetch code whose AND with 4'b1010 is zero marks a demand request. When a demand merges into a prefetch-only entry, the prefetch-only flag clears. The demand time is set to the number of clock edges since reset was released, counted before the accepting edge.
- R8: On that same event, late_sw_count increments if the entry's first prefetch code was 2, and late_hw_count increments if it was 8.
- R9: Allocation clears the draining, ordering and write-seen flags, the count and the demand time. The prefetch-only flag is set exactly when the first request's code AND 4'b1010 is nonzero. After reset, both late counters are zero and rsp_valid is low.
- R10: rsp_valid is high in exactly the cycle after a cycle with req_valid high. rsp_has_writes, rsp_only_pref and rsp_demand show the entry state after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Start an entry |
| alloc_idx | input | $clog2(NUM_ENT) | Entry to start |
| alloc_kind | input | 2 | Type of the first request |
| alloc_pref | input | 4 | Prefetch code of the first request |
| rel_valid | input | 1 | Mark an entry as draining |
| rel_idx | input | $clog2(NUM_ENT) | Entry to mark |
| req_valid | input | 1 | New request present |
| req_idx | input | $clog2(NUM_ENT) | Matching entry |
| req_kind | input | 2 | Request type: 0 read, 1 write, 2 read-modify-write, 3 upgrade |
| req_pref | input | 4 | Request prefetch code |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 2 | 0 merged, 1 drain hold, 2 ordering hold, 3 full |
| rsp_slot | output | $clog2(MAX_COAL) | Merge count before the request |
| rsp_has_writes | output | 1 | Entry write-seen flag after the request |
| rsp_only_pref | output | 1 | Entry prefetch-only flag after the request |
| rsp_demand | output | TIME_W | Entry demand time after the request |
| late_sw_count | output | LATE_W | Late software prefetches |
| late_hw_count | output | LATE_W | Late hardware prefetches |

## Verification
The hardest case to reach is a fully loaded entry that is also under a sticky hold or draining. Reaching it takes a long run of merges on one entry, with no read-first entry being hit by a write, followed by a hold or drain event. Directed sequences fill an entry to MAX_COAL-1 and then drain it. Random traffic mixes read-first and write-first allocations with rare drains, so that long merge chains and late demand hits on prefetch-only entries occur repeatedly.

// File: rtl/mshr_coal_pkg.sv
package mshr_coal_pkg;

    typedef enum logic [1:0] {
        K_READ    = 2'd0,
        K_WRITE   = 2'd1,
        K_RMW     = 2'd2,
        K_UPGRADE = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RES_MERGED    = 2'd0,
        RES_HOLD_DRN  = 2'd1,
        RES_HOLD_ORD  = 2'd2,
        RES_HOLD_FULL = 2'd3
    } merge_res_e;

    typedef enum logic [1:0] {
        PC_NONE  = 2'd0,
        PC_SOFT  = 2'd1,
        PC_HW    = 2'd2,
        PC_OTHER = 2'd3
    } pf_class_e;

    typedef struct packed {
        logic      draining;
        logic      ord_hold;
        logic      has_wr;
        logic      only_pf;
        logic      prim_rd;
        pf_class_e pcls;
    } ent_flags_t;

    function automatic logic is_demand(input logic [3:0] pref);
        return (pref & 4'b1010) == 4'b0000;
    endfunction

    function automatic pf_class_e pf_class(input logic [3:0] pref);
        if (pref == 4'd2)       return PC_SOFT;
        else if (pref == 4'd8)  return PC_HW;
        else if (is_demand(pref)) return PC_NONE;
        else                    return PC_OTHER;
    endfunction

endpackage

// File: rtl/mshr_merge_decide.sv
module mshr_merge_decide
    import mshr_coal_pkg::*;
#(
    parameter int MAX_COAL = 8,
    localparam int CNT_W   = $clog2(MAX_COAL)
) (
    input  ent_flags_t       cur_flags,
    input  logic [CNT_W-1:0] cur_cnt,
    input  req_kind_e        kind,
    input  logic [3:0]       pref,
    output merge_res_e       code,
    output ent_flags_t       nxt_flags,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             changed,
    output logic             take_dem,
    output logic             late_sw,
    output logic             late_hw
);
    always_comb begin
        nxt_flags = cur_flags;
        nxt_cnt   = cur_cnt;
        code      = RES_MERGED;
        changed   = 1'b0;
        take_dem  = 1'b0;
        late_sw   = 1'b0;
        late_hw   = 1'b0;
        if (cur_flags.draining) begin
            code = RES_HOLD_DRN;
        end else if (cur_flags.ord_hold) begin
            code = RES_HOLD_ORD;
        end else if (kind != K_READ && cur_flags.prim_rd) begin
            code               = RES_HOLD_ORD;
            nxt_flags.ord_hold = 1'b1;
            changed            = 1'b1;
        end else if (cur_cnt == CNT_W'(MAX_COAL - 1)) begin
            code = RES_HOLD_FULL;
        end else begin
            changed          = 1'b1;
            nxt_cnt          = cur_cnt + CNT_W'(1);
            nxt_flags.has_wr = (kind == K_WRITE) || (kind == K_RMW);
            if (cur_flags.only_pf && is_demand(pref)) begin
                nxt_flags.only_pf = 1'b0;
                take_dem          = 1'b1;
                late_sw           = (cur_flags.pcls == PC_SOFT);
                late_hw           = (cur_flags.pcls == PC_HW);
            end
        end
    end
endmodule

// File: rtl/mshr_entry_file.sv
module mshr_entry_file
    import mshr_coal_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int MAX_COAL = 8,
    parameter int TIME_W   = 16,
    localparam int IW      = $clog2(NUM_ENT),
    localparam int CNT_W   = $clog2(MAX_COAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [IW-1:0]     alloc_idx,
    input  req_kind_e         alloc_kind,
    input  logic [3:0]        alloc_pref,
    input  logic              rel_valid,
    input  logic [IW-1:0]     rel_idx,
    input  logic              upd_valid,
    input  logic [IW-1:0]     upd_idx,
    input  ent_flags_t        upd_flags,
    input  logic [CNT_W-1:0]  upd_cnt,
    input  logic              upd_dem_we,
    input  logic [TIME_W-1:0] upd_dem,
    output ent_flags_t        flags_q [NUM_ENT],
    output logic [CNT_W-1:0]  cnt_q   [NUM_ENT],
    output logic [TIME_W-1:0] dem_q   [NUM_ENT]
);
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic hit_alloc, hit_upd, hit_rel;
        assign hit_alloc = alloc_valid && (alloc_idx == IW'(i));
        assign hit_upd   = upd_valid   && (upd_idx   == IW'(i));
        assign hit_rel   = rel_valid   && (rel_idx   == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= '0;
                cnt_q[i]   <= '0;
                dem_q[i]   <= '0;
            end else if (hit_alloc) begin
                flags_q[i].draining <= 1'b0;
                flags_q[i].ord_hold <= 1'b0;
                flags_q[i].has_wr   <= 1'b0;
                flags_q[i].only_pf  <= !is_demand(alloc_pref);
                flags_q[i].prim_rd  <= (alloc_kind == K_READ);
                flags_q[i].pcls     <= pf_class(alloc_pref);
                cnt_q[i]            <= '0;
                dem_q[i]            <= '0;
            end else begin
                if (hit_upd) begin
                    flags_q[i] <= upd_flags;
                    cnt_q[i]   <= upd_cnt;
                end
                if (hit_upd && upd_dem_we) dem_q[i] <= upd_dem;
                if (hit_rel) flags_q[i].draining <= 1'b1;
            end
        end

        assert_ord_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            flags_q[i].ord_hold && !hit_alloc |=> flags_q[i].ord_hold);

        assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
            cnt_q[i] <= CNT_W'(MAX_COAL - 1));

        assert_onlypf_rise_R9: assert property (@(posedge clk) disable iff (rst)
            !flags_q[i].only_pf && !hit_alloc |=> !flags_q[i].only_pf);
    end
endmodule

// File: rtl/mshr_late_count.sv
module mshr_late_count #(
    parameter int LATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_sw,
    input  logic              inc_hw,
    output logic [LATE_W-1:0] sw_count,
    output logic [LATE_W-1:0] hw_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_count <= '0;
            hw_count <= '0;
        end else begin
            if (inc_sw) sw_count <= sw_count + LATE_W'(1);
            if (inc_hw) hw_count <= hw_count + LATE_W'(1);
        end
    end

    assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(inc_sw && inc_hw));
endmodule

// File: rtl/mshr_coal_ctrl.sv
module mshr_coal_ctrl
    import mshr_coal_pkg::*;
#(
    parameter int NUM_ENT  = 4,
    parameter int MAX_COAL = 8,
    parameter int TIME_W   = 16,
    parameter int LATE_W   = 16,
    localparam int IW      = $clog2(NUM_ENT),
    localparam int CNT_W   = $clog2(MAX_COAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [IW-1:0]     alloc_idx,
    input  logic [1:0]        alloc_kind,
    input  logic [3:0]        alloc_pref,
    input  logic              rel_valid,
    input  logic [IW-1:0]     rel_idx,
    input  logic              req_valid,
    input  logic [IW-1:0]     req_idx,
    input  logic [1:0]        req_kind,
    input  logic [3:0]        req_pref,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [CNT_W-1:0]  rsp_slot,
    output logic              rsp_has_writes,
    output logic              rsp_only_pref,
    output logic [TIME_W-1:0] rsp_demand,
    output logic [LATE_W-1:0] late_sw_count,
    output logic [LATE_W-1:0] late_hw_count
);
    ent_flags_t        flags_q [NUM_ENT];
    logic [CNT_W-1:0]  cnt_q   [NUM_ENT];
    logic [TIME_W-1:0] dem_q   [NUM_ENT];
    logic [TIME_W-1:0] cyc;

    ent_flags_t       nxt_flags;
    logic [CNT_W-1:0] nxt_cnt;
    merge_res_e       code;
    logic             changed, take_dem, late_sw, late_hw;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + TIME_W'(1);
    end

    mshr_merge_decide #(.MAX_COAL(MAX_COAL)) u_decide (
        .cur_flags (flags_q[req_idx]),
        .cur_cnt   (cnt_q[req_idx]),
        .kind      (req_kind_e'(req_kind)),
        .pref      (req_pref),
        .code      (code),
        .nxt_flags (nxt_flags),
        .nxt_cnt   (nxt_cnt),
        .changed   (changed),
        .take_dem  (take_dem),
        .late_sw   (late_sw),
        .late_hw   (late_hw)
    );

    mshr_entry_file #(.NUM_ENT(NUM_ENT), .MAX_COAL(MAX_COAL), .TIME_W(TIME_W)) u_file (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_idx   (alloc_idx),
        .alloc_kind  (req_kind_e'(alloc_kind)),
        .alloc_pref  (alloc_pref),
        .rel_valid   (rel_valid),
        .rel_idx     (rel_idx),
        .upd_valid   (req_valid && changed),
        .upd_idx     (req_idx),
        .upd_flags   (nxt_flags),
        .upd_cnt     (nxt_cnt),
        .upd_dem_we  (take_dem),
        .upd_dem     (cyc),
        .flags_q     (flags_q),
        .cnt_q       (cnt_q),
        .dem_q       (dem_q)
    );

    mshr_late_count #(.LATE_W(LATE_W)) u_late (
        .clk      (clk),
        .rst      (rst),
        .inc_sw   (req_valid && late_sw),
        .inc_hw   (req_valid && late_hw),
        .sw_count (late_sw_count),
        .hw_count (late_hw_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_code       <= '0;
            rsp_slot       <= '0;
            rsp_has_writes <= 1'b0;
            rsp_only_pref  <= 1'b0;
            rsp_demand     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code       <= code;
                rsp_slot       <= cnt_q[req_idx];
                rsp_has_writes <= nxt_flags.has_wr;
                rsp_only_pref  <= nxt_flags.only_pf;
                rsp_demand     <= take_dem ? cyc : dem_q[req_idx];
            end
        end
    end

    assert_drain_first_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && flags_q[req_idx].draining |=> rsp_code == RES_HOLD_DRN);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/sim_mshr_coal_ctrl.sv
`timescale 1ns/1ps
module sim_mshr_coal_ctrl;
    localparam int NE = 4;
    localparam int MC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 0, rel_valid = 0, req_valid = 0;
    logic [1:0] alloc_idx = 0, rel_idx = 0, req_idx = 0;
    logic [1:0] alloc_kind = 0, req_kind = 0;
    logic [3:0] alloc_pref = 0, req_pref = 0;
    logic rsp_valid, rsp_has_writes, rsp_only_pref;
    logic [1:0] rsp_code;
    logic [2:0] rsp_slot;
    logic [15:0] rsp_demand, late_sw_count, late_hw_count;

    always #2 clk = ~clk;

    mshr_coal_ctrl u0 (.*);

    int total = 0, bad = 0;
    int tcyc = 0;
    bit m_drn[NE], m_ord[NE], m_hw[NE], m_only[NE], m_prd[NE];
    int m_pc[NE], m_cnt[NE], m_dem[NE];
    int e_sw = 0, e_hw = 0;

    always @(posedge clk) tcyc <= rst ? 0 : tcyc + 1;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_alloc(int e, int k, int p);
        alloc_valid = 1; alloc_idx = 2'(e); alloc_kind = 2'(k); alloc_pref = 4'(p);
        @(negedge clk);
        alloc_valid = 0;
        m_drn[e] = 0; m_ord[e] = 0; m_hw[e] = 0; m_cnt[e] = 0; m_dem[e] = 0;
        m_only[e] = (p & 10) != 0; m_prd[e] = (k == 0); m_pc[e] = p;
    endtask

    task automatic do_rel(int e);
        rel_valid = 1; rel_idx = 2'(e);
        @(negedge clk);
        rel_valid = 0;
        m_drn[e] = 1;
    endtask

    task automatic do_req(int e, int k, int p);
        int ec, es; string tg;
        es = m_cnt[e];
        if (m_drn[e]) begin ec = 1; tg = "R1"; end
        else if (m_ord[e]) begin ec = 2; tg = "R2"; end
        else if (k != 0 && m_prd[e]) begin ec = 2; tg = "R3"; m_ord[e] = 1; end
        else if (m_cnt[e] == MC - 1) begin ec = 3; tg = "R4"; end
        else begin
            ec = 0; tg = "R5";
            m_cnt[e]++;
            m_hw[e] = (k == 1 || k == 2);
            if (m_only[e] && (p & 10) == 0) begin
                m_only[e] = 0;
                m_dem[e] = tcyc & 16'hFFFF;
                if (m_pc[e] == 2) e_sw++;
                if (m_pc[e] == 8) e_hw++;
            end
        end
        req_valid = 1; req_idx = 2'(e); req_kind = 2'(k); req_pref = 4'(p);
        @(negedge clk);
        req_valid = 0;
        chk("R10 rsp_valid", int'(rsp_valid), 1);
        chk({tg, " code"}, int'(rsp_code), ec);
        chk({tg, " slot"}, int'(rsp_slot), es);
        chk("R6 has_writes", int'(rsp_has_writes), int'(m_hw[e]));
        chk("R7 only_pref", int'(rsp_only_pref), int'(m_only[e]));
        chk("R7 demand", int'(rsp_demand), m_dem[e]);
        chk("R8 late_sw", int'(late_sw_count), e_sw);
        chk("R8 late_hw", int'(late_hw_count), e_hw);
    endtask

    function automatic int pick_pref();
        int r = int'($urandom % 6);
        case (r)
            0: return 0; 1: return 2; 2: return 8;
            3: return 10; 4: return 1; default: return 4;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset rsp_valid", int'(rsp_valid), 0);
        chk("R9 reset late_sw", int'(late_sw_count), 0);
        chk("R9 reset late_hw", int'(late_hw_count), 0);
        for (int e = 0; e < NE; e++) do_alloc(e, 1, 0);

        // R3 then sticky R2 on a read-first entry
        do_alloc(0, 0, 0);
        do_req(0, 1, 0);
        do_req(0, 0, 0);
        @(negedge clk);
        chk("R10 quiet", int'(rsp_valid), 0);
        do_alloc(0, 0, 0);
        do_req(0, 0, 0);

        // prefetch-only entry, late demand (R7, R8), then fill (R4)
        do_alloc(1, 1, 2);
        do_req(1, 0, 8);
        do_req(1, 2, 0);
        for (int j = 0; j < 6; j++) do_req(1, 3, 0);
        do_req(1, 0, 0);
        do_rel(1);
        do_req(1, 0, 0);

        // hardware prefetch class
        do_alloc(2, 0, 8);
        do_req(2, 0, 4);

        for (int it = 0; it < 4000; it++) begin
            int op = int'($urandom % 40);
            int e = int'($urandom % NE);
            if (op < 3) do_alloc(e, int'($urandom % 4), pick_pref());
            else if (op == 3) do_rel(e);
            else do_req(e, (op % 3 == 0) ? int'($urandom % 4) : 0, pick_pref());
        end
        summary();
    end
endmodule